// File: doc/BRIEF.md
# Length-Tracking Command/Response Buffer

This block is the byte store that sits behind a command data port. A host pushes a command into it in transfers of 1 to 64 bytes. Each transfer arrives one byte per clock, and a marker flags its final byte. While the bytes stream in, the block picks out the 32-bit length carried in header bytes 2 to 5, most significant byte first. After each completed transfer it decides whether more bytes are still owed, and it shows this on an expect flag. A transfer that would run past the buffer's capacity is thrown away. The block then rewinds its fill level to zero and asks the lifecycle controller to go back to the ready state.

The lifecycle controller owns the state machine and supplies the current state as an input. The buffer answers with single-cycle request pulses: one to enter receiving when the first byte of a command arrives, one to return to ready on overflow, and one to report that the response has been read out completely. Once a response is in place, the controller loads its length. The host then reads the response byte by byte. Each read past the stored length returns 0xFF and leaves the read pointer where it is.

Top module: `cmd_resp_buf`

## Requirements
- R1: Bytes accepted during a transfer are stored in arrival order starting at the current fill level. `fill_o` rises by the transfer length after the final byte and never exceeds DEPTH.
- R2: If the first byte of a transfer arrives while `state_i` is ready (encoding 1) and `fill_o` is 0, that transfer is accepted. `req_rx_o` pulses for one cycle after that byte.
- R3: A transfer whose first byte arrives in any other situation is ignored: the state is idle (0), executing (3) or completing (4), or it is ready with a nonzero fill. `fill_o` and `expect_o` do not change. Receiving is encoding 2.
- R4: If fill plus transfer length would exceed DEPTH, the transfer is discarded when its final byte arrives. `fill_o` becomes 0 and `req_rdy_o` pulses for one cycle.
- R5: After a committed transfer that leaves fewer than 6 bytes in the buffer, `expect_o` is 1.
- R6: Once 6 or more bytes are present, buffer bytes 2,3,4,5 form a 32-bit length with byte 2 most significant. After each committed transfer, `expect_o` is 1 while the fill is below that length and 0 once the fill reaches or exceeds it.
- R7: Each `rd_en` cycle with the read pointer below `fill_o` returns the byte at the read pointer and advances the pointer by one.
- R8: Each `rd_en` cycle with the read pointer equal to `fill_o` returns 0xFF and leaves the pointer unchanged.
- R9: `drained_o` pulses together with the read data of any read after which the read pointer equals `fill_o`.
- R10: While `state_i` is idle, both the fill level and the read pointer are held at 0.
- R11: `resp_load` sets `fill_o` to `resp_len` and rewinds the read pointer to 0.
- R12: `rd_vld_o` and `rd_data_o` present the result of a read in the cycle after `rd_en` is sampled. `rd_vld_o` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| state_i | input | 3 | Lifecycle state: 0 idle, 1 ready, 2 receiving, 3 executing, 4 completing |
| wr_en | input | 1 | Write byte strobe |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Marks the final byte of a transfer |
| rd_en | input | 1 | Read byte request |
| resp_load | input | 1 | Load response length and rewind read pointer |
| resp_len | input | AW+1 | Response length in bytes |
| rd_data_o | output | 8 | Read byte, or 0xFF past the end |
| rd_vld_o | output | 1 | Read result valid |
| expect_o | output | 1 | More command bytes are owed |
| req_rx_o | output | 1 | Pulse: enter receiving |
| req_rdy_o | output | 1 | Pulse: overflow, return to ready |
| drained_o | output | 1 | Pulse: response fully read |
| fill_o | output | AW+1 | Current fill level in bytes |

## Verification
The bench builds the buffer with DEPTH 64 and MAX_XFER 16. At that size a handful of transfers reaches both the exact-capacity boundary and overflow by a single byte. With the small capacity, the bench can sweep every command length from 6 to 30, each split into 1-, 4- and 16-byte transfers, and read back every byte plus the 0xFF padding. Header lengths whose byte order matters, and declared lengths longer than the bytes actually sent, exercise the expect decision separately from the fill count.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  typedef enum logic [2:0] {
    LC_IDLE       = 3'd0,
    LC_READY      = 3'd1,
    LC_RECEIVING  = 3'd2,
    LC_EXECUTING  = 3'd3,
    LC_COMPLETING = 3'd4
  } lc_state_e;
endpackage

// File: rtl/cmdbuf_ram.sv
module cmdbuf_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmdbuf_hdr.sv
// Snoops header bytes as they are stored and decides after each committed
// transfer whether the command is still short.
module cmdbuf_hdr #(
  parameter int AW       = 11,
  parameter int HDR_LEN  = 6,
  parameter int SIZE_OFS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap_en,
  input  logic [AW:0] cap_addr,
  input  logic [7:0]  cap_byte,
  input  logic        commit,
  input  logic [AW:0] commit_fill,
  output logic        expect_o
);
  logic [31:0] size_q, size_d;
  logic [AW:0] rel;
  logic [1:0]  idx;
  logic        in_field;

  assign rel      = cap_addr - (AW+1)'(SIZE_OFS);
  assign idx      = rel[1:0];
  assign in_field = (cap_addr >= (AW+1)'(SIZE_OFS)) && (cap_addr < (AW+1)'(SIZE_OFS + 4));

  always_comb begin
    size_d = size_q;
    if (cap_en && in_field) size_d[8*(3-idx) +: 8] = cap_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q   <= '0;
      expect_o <= 1'b0;
    end else begin
      size_q <= size_d;
      if (commit)
        expect_o <= (commit_fill < (AW+1)'(HDR_LEN)) || (32'(commit_fill) < size_d);
    end
  end
endmodule

// File: rtl/cmdbuf_rd.sv
// Read pointer: clamps to the fill level and pads with 0xFF past the end.
module cmdbuf_rd #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rd_en,
  input  logic [AW:0]   fill,
  input  logic [7:0]    ram_q,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic [7:0]    rd_data,
  output logic          rd_vld,
  output logic          drained
);
  logic [AW:0] rp, rp_nxt;
  logic        avail, hit;

  assign avail     = rp < fill;
  assign ram_re    = rd_en && avail;
  assign ram_raddr = rp[AW-1:0];
  assign rp_nxt    = avail ? rp + 1'b1 : rp;
  assign rd_data   = hit ? ram_q : 8'hFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp      <= '0;
      hit     <= 1'b0;
      rd_vld  <= 1'b0;
      drained <= 1'b0;
    end else begin
      rd_vld  <= rd_en;
      hit     <= ram_re;
      drained <= rd_en && (rp_nxt == fill);
      if (clear)      rp <= '0;
      else if (rd_en) rp <= rp_nxt;
    end
  end
endmodule

// File: rtl/cmd_resp_buf.sv
module cmd_resp_buf #(
  parameter int DEPTH    = 2048,
  parameter int MAX_XFER = 64,
  parameter int HDR_LEN  = 6,
  parameter int SIZE_OFS = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(MAX_XFER + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  state_i,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        wr_last,
  input  logic        rd_en,
  input  logic        resp_load,
  input  logic [AW:0] resp_len,
  output logic [7:0]  rd_data_o,
  output logic        rd_vld_o,
  output logic        expect_o,
  output logic        req_rx_o,
  output logic        req_rdy_o,
  output logic        drained_o,
  output logic [AW:0] fill_o
);
  import cmdbuf_pkg::*;

  lc_state_e     st;
  logic [AW:0]   wp;
  logic [CW-1:0] cnt;
  logic          in_xfer, xfer_ok, first, open_ok, accept;
  logic [AW+1:0] addr, total;
  logic          ram_we, overflow, commit, rd_clear;
  logic          ram_re;
  logic [AW-1:0] ram_raddr;
  logic [7:0]    ram_q;

  assign st       = lc_state_e'(state_i);
  assign first    = !in_xfer;
  assign open_ok  = (st == LC_RECEIVING) || (st == LC_READY && wp == '0);
  assign accept   = wr_en && (first ? open_ok : (xfer_ok && st != LC_IDLE));
  assign addr     = {1'b0, wp} + (AW+2)'(cnt);
  assign total    = addr + 1'b1;
  assign ram_we   = accept && (addr < (AW+2)'(DEPTH));
  assign overflow = accept && wr_last && (total > (AW+2)'(DEPTH));
  assign commit   = accept && wr_last && !(total > (AW+2)'(DEPTH));
  assign rd_clear = resp_load || (st == LC_IDLE);
  assign fill_o   = wp;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      cnt       <= '0;
      in_xfer   <= 1'b0;
      xfer_ok   <= 1'b0;
      req_rx_o  <= 1'b0;
      req_rdy_o <= 1'b0;
    end else begin
      req_rx_o  <= wr_en && first && st == LC_READY && wp == '0;
      req_rdy_o <= overflow;
      if (wr_en) begin
        if (wr_last) begin
          in_xfer <= 1'b0;
          cnt     <= '0;
        end else begin
          in_xfer <= 1'b1;
          xfer_ok <= accept;
          if (cnt != '1) cnt <= cnt + 1'b1;
        end
      end
      if (resp_load)          wp <= resp_len;
      else if (st == LC_IDLE) wp <= '0;
      else if (overflow)      wp <= '0;
      else if (commit)        wp <= total[AW:0];
    end
  end

  cmdbuf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(addr[AW-1:0]), .wdata(wr_data),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );

  cmdbuf_hdr #(.AW(AW), .HDR_LEN(HDR_LEN), .SIZE_OFS(SIZE_OFS)) u_hdr (
    .clk(clk), .rst(rst), .cap_en(ram_we), .cap_addr(addr[AW:0]),
    .cap_byte(wr_data), .commit(commit), .commit_fill(total[AW:0]),
    .expect_o(expect_o)
  );

  cmdbuf_rd #(.AW(AW)) u_rd (
    .clk(clk), .rst(rst), .clear(rd_clear), .rd_en(rd_en), .fill(wp),
    .ram_q(ram_q), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .rd_data(rd_data_o), .rd_vld(rd_vld_o), .drained(drained_o)
  );
endmodule

// File: rtl/cmd_resp_buf_chk.sv
module cmd_resp_buf_chk #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  state_i,
  input logic        wr_en,
  input logic        rd_en,
  input logic        resp_load,
  input logic [AW:0] fill_o,
  input logic        rd_vld_o,
  input logic        req_rx_o,
  input logic        req_rdy_o,
  input logic        drained_o
);
  AST_FILL_CAP: assert property (@(posedge clk) disable iff (rst)
    !$past(resp_load) |-> fill_o <= (AW+1)'(DEPTH)); // R1
  AST_RX_FROM_READY: assert property (@(posedge clk) disable iff (rst)
    req_rx_o |-> ($past(state_i) == 3'd1 && $past(wr_en))); // R2
  AST_OVF_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (req_rdy_o && !$past(resp_load)) |-> fill_o == '0); // R4
  AST_DRAIN_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    drained_o |-> rd_vld_o); // R9
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (state_i == 3'd0 && !resp_load) |=> fill_o == '0); // R10
  AST_RD_VLD_NEXT: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_vld_o); // R12
  AST_RD_VLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_vld_o); // R12
endmodule

bind cmd_resp_buf cmd_resp_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .state_i(state_i), .wr_en(wr_en), .rd_en(rd_en),
  .resp_load(resp_load), .fill_o(fill_o), .rd_vld_o(rd_vld_o),
  .req_rx_o(req_rx_o), .req_rdy_o(req_rdy_o), .drained_o(drained_o)
);

// File: tb/cmd_resp_buf_bench.sv
`timescale 1ns/1ps
module cmd_resp_buf_bench;
  localparam int DEPTH = 64;
  localparam int MAX_XFER = 16;
  localparam int AW = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] state_i = 3'd0;
  logic wr_en = 1'b0, wr_last = 1'b0, rd_en = 1'b0, resp_load = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [AW:0] resp_len = '0;
  logic [7:0] rd_data_o;
  logic rd_vld_o, expect_o, req_rx_o, req_rdy_o, drained_o;
  logic [AW:0] fill_o;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cmd_resp_buf #(.DEPTH(DEPTH), .MAX_XFER(MAX_XFER)) u_cmd_resp_buf (
    .clk(clk), .rst(rst), .state_i(state_i), .wr_en(wr_en), .wr_data(wr_data),
    .wr_last(wr_last), .rd_en(rd_en), .resp_load(resp_load), .resp_len(resp_len),
    .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o), .expect_o(expect_o),
    .req_rx_o(req_rx_o), .req_rdy_o(req_rdy_o), .drained_o(drained_o), .fill_o(fill_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] byte_at(input int i, input logic [31:0] s, input int l);
    if (i >= 2 && i <= 5) return 8'(s >> (8 * (5 - i)));
    return 8'(i * 13 + l * 3 + 1);
  endfunction

  task automatic send_xfer(input int start, input int n, input logic [31:0] s,
                           input int l, input bit first_cmd);
    for (int j = 0; j < n; j++) begin
      wr_en = 1'b1;
      wr_data = byte_at(start + j, s, l);
      wr_last = (j == n - 1);
      tick();
      if (j == 0 && first_cmd) begin
        chk(req_rx_o == 1'b1, "R2 req_rx", int'(req_rx_o), 1);
        state_i = 3'd2;
      end
    end
    wr_en = 1'b0;
    wr_last = 1'b0;
  endtask

  task automatic run_cmd(input int l, input logic [31:0] s, input int c);
    int sent = 0;
    bit want;
    state_i = 3'd0;
    tick();
    state_i = 3'd1;
    while (sent < l) begin
      int n = (l - sent < c) ? l - sent : c;
      send_xfer(sent, n, s, l, sent == 0);
      sent += n;
      chk(fill_o == (AW+1)'(sent), "R1 fill", int'(fill_o), sent);
      chk(req_rdy_o == 1'b0, "R4 no overflow", int'(req_rdy_o), 0);
      want = (sent < 6) || (32'(sent) < s);
      if (sent < 6) chk(expect_o == want, "R5 expect short", int'(expect_o), int'(want));
      else          chk(expect_o == want, "R6 expect vs length", int'(expect_o), int'(want));
    end
  endtask

  task automatic readback(input int l, input logic [31:0] s, input int lenb);
    state_i = 3'd4;
    resp_load = 1'b1;
    resp_len = (AW+1)'(l);
    tick();
    resp_load = 1'b0;
    chk(fill_o == (AW+1)'(l), "R11 load fill", int'(fill_o), l);
    for (int k = 0; k < l + 2; k++) begin
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
      chk(rd_vld_o == 1'b1, "R12 rd_vld", int'(rd_vld_o), 1);
      if (k < l) chk(rd_data_o == byte_at(k, s, lenb), "R7 data", int'(rd_data_o), int'(byte_at(k, s, lenb)));
      else       chk(rd_data_o == 8'hFF, "R8 pad", int'(rd_data_o), 255);
      chk(drained_o == (k >= l - 1), "R9 drained", int'(drained_o), int'(k >= l - 1));
    end
    tick();
    chk(rd_vld_o == 1'b0, "R12 quiet", int'(rd_vld_o), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R1 watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    chk(fill_o == 0, "R1 reset fill", int'(fill_o), 0);
    chk(expect_o == 0, "R5 reset expect", int'(expect_o), 0);
    chk(rd_vld_o == 0, "R12 reset vld", int'(rd_vld_o), 0);
    chk(req_rx_o == 0 && req_rdy_o == 0, "R2 reset pulses", int'(req_rx_o), 0);

    // R3: writes in idle and executing are ignored
    state_i = 3'd0;
    send_xfer(0, 3, 32'd9, 9, 1'b0);
    chk(fill_o == 0, "R3 idle write", int'(fill_o), 0);
    chk(req_rx_o == 0, "R3 no req in idle", int'(req_rx_o), 0);
    state_i = 3'd3;
    send_xfer(0, 2, 32'd9, 9, 1'b0);
    chk(fill_o == 0, "R3 executing write", int'(fill_o), 0);
    state_i = 3'd4;
    send_xfer(0, 4, 32'd9, 9, 1'b0);
    chk(fill_o == 0, "R3 completing write", int'(fill_o), 0);

    // Sweep of lengths and transfer sizes
    for (int l = 6; l <= 30; l++) begin
      run_cmd(l, 32'(l), 1);  readback(l, 32'(l), l);
      run_cmd(l, 32'(l), 4);  readback(l, 32'(l), l);
      run_cmd(l, 32'(l), 16); readback(l, 32'(l), l);
      readback(l, 32'(l), l);
    end

    // R6: declared length longer than sent, and byte order
    run_cmd(10, 32'd20, 3);
    chk(expect_o == 1, "R6 owed bytes", int'(expect_o), 1);
    run_cmd(8, 32'h0100_0000, 8);
    chk(expect_o == 1, "R6 msb first", int'(expect_o), 1);
    run_cmd(8, 32'h0000_0008, 8);
    chk(expect_o == 0, "R6 exact length", int'(expect_o), 0);

    // R3: ready with nonzero fill ignores a new transfer
    state_i = 3'd1;
    send_xfer(0, 2, 32'd5, 5, 1'b0);
    chk(fill_o == 8, "R3 ready nonzero fill", int'(fill_o), 8);
    chk(expect_o == 0, "R3 expect unchanged", int'(expect_o), 0);

    // R10: idle clears fill
    state_i = 3'd0;
    tick();
    chk(fill_o == 0, "R10 idle clear", int'(fill_o), 0);

    // R4: overflow by one byte
    run_cmd(60, 32'd100, 15);
    send_xfer(60, 5, 32'd100, 60, 1'b0);
    chk(req_rdy_o == 1, "R4 overflow pulse", int'(req_rdy_o), 1);
    chk(fill_o == 0, "R4 overflow fill", int'(fill_o), 0);
    tick();
    chk(req_rdy_o == 0, "R4 single pulse", int'(req_rdy_o), 0);
    state_i = 3'd1;
    send_xfer(0, 6, 32'd6, 6, 1'b1);
    chk(fill_o == 6, "R2 accept after overflow", int'(fill_o), 6);
    chk(expect_o == 0, "R6 after overflow", int'(expect_o), 0);

    // R1/R4: exactly full is legal
    run_cmd(64, 32'd64, 16);
    chk(expect_o == 0, "R6 full command", int'(expect_o), 0);
    readback(64, 32'd64, 64);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule